// File: doc/BRIEF.md
# Indirect Load-Store Address Generator

This block forms the memory byte address and the new base-register value for one indirect load or store. A request carries a base register's contents and identity (bank and index), an offset source, the access width, a modification mode and the circular-mode setting for that base register. One clock later the block returns the address to use for memory, the value to write back into the base register, a write-back strobe, and a flag for request forms that are not allowed.

The offset is a short 5-bit immediate, the value of an index register, or a 15-bit immediate. The 15-bit form is allowed only for the two dedicated pointer registers. The offset is scaled by the access width before it is added to or subtracted from the base. Pre-modify modes send the updated pointer to memory. Post-modify modes send the original base to memory and only write the updated pointer back. When circular mode is enabled on an eligible register, the update wraps inside a power-of-two block.

The register file, the decode and the memory access are outside this block.

Top module: `ldst_agen`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `out_valid`, `wb_en` and `bad_form` are 0, and `mem_addr` and `wb_data` are 0.
- R2: Results appear on the outputs on the cycle after the edge that samples `req_valid`=1. `out_valid` is high on exactly those cycles.
- R3: The offset is shifted left by the access width code `acc_size`: 0 is byte (x1), 1 is halfword (x2), 2 is word (x4), and 3 is treated as word. Example: a word access with offset 9 moves the address by 36 bytes.
- R4: `off_kind` picks the unscaled offset: 0 takes `imm[4:0]`, 1 takes `index_val`, and 2 takes `imm[14:0]`. All offsets are unsigned.
- R5: Modes 1 (pre-increment) and 2 (pre-decrement) give `mem_addr` = `wb_data` = base +/- scaled offset, with `wb_en`=1.
- R6: Modes 3 (post-increment) and 4 (post-decrement) give `mem_addr` = base and `wb_data` = base +/- scaled offset, with `wb_en`=1.
- R7: Modes 0 (add, no modification) and 5 (subtract, no modification) give `mem_addr` = base +/- scaled offset, with `wb_en`=0.
- R8: `bad_form` is 1 and `wb_en` is 0 in three cases: the mode is 6 or 7, `off_kind` is 3, or `off_kind`=2 is used other than with mode 0 and a base of bank 1 (`base_bank`=1) with index 14 or 15.
- R9: Circular updating applies only when `circ_en`=1 and `base_idx` is 4 to 7, in either bank. Every other register is linear, whatever `circ_en` says.
- R10: In circular mode with block field N=`circ_size`, only address bits N..0 take the result of the add or subtract. The bits above N keep the base value. The block size is 2^(N+1) bytes.
- R11: Linear arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| base_bank | input | 1 | Bank of the base register |
| base_idx | input | 4 | Index of the base register |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents |
| imm | input | 15 | Immediate offset field |
| off_kind | input | 2 | Offset source select |
| acc_size | input | 2 | Access width code |
| mode | input | 3 | Modification mode |
| circ_en | input | 1 | Circular mode selected for this base register |
| circ_size | input | 5 | Circular block size field N |
| out_valid | output | 1 | Results valid |
| mem_addr | output | 32 | Byte address for the access |
| wb_data | output | 32 | Updated base register value |
| wb_en | output | 1 | Write `wb_data` back to the base register |
| bad_form | output | 1 | Request form not allowed |

## Verification
Every result is registered once, so each output is due on the first rising edge after the edge that samples the request. The bench drives a request on a falling edge, lets one rising edge pass, and samples at the next falling edge. It then drops `req_valid` so that an idle cycle can show `out_valid` low again. A sweep covers every register identity, mode, width, offset source and circular setting. A few directed cases pin down the scaling example, the 32-bit wrap and the block-size extremes.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [2:0] {
    MD_ADD_ONLY = 3'd0,
    MD_PRE_INC  = 3'd1,
    MD_PRE_DEC  = 3'd2,
    MD_POST_INC = 3'd3,
    MD_POST_DEC = 3'd4,
    MD_SUB_ONLY = 3'd5
  } mod_mode_e;

  typedef enum logic [1:0] {
    OK_SHORT = 2'd0,
    OK_INDEX = 2'd1,
    OK_LONG  = 2'd2
  } off_kind_e;
endpackage

// File: rtl/agen_offset.sv
module agen_offset #(
  parameter int AW     = 32,
  parameter int SHORTW = 5,
  parameter int IMMW   = 15
) (
  input  logic [1:0]      kind,
  input  logic [IMMW-1:0] imm,
  input  logic [AW-1:0]   index_val,
  input  logic [1:0]      size,
  output logic [AW-1:0]   scaled
);
  import agen_pkg::*;
  logic [AW-1:0] raw;
  logic [1:0]    shamt;

  always_comb begin
    case (kind)
      OK_SHORT: raw = AW'(imm[SHORTW-1:0]);
      OK_INDEX: raw = index_val;
      default:  raw = AW'(imm);
    endcase
    shamt  = (size == 2'd3) ? 2'd2 : size;
    scaled = raw << shamt;
  end
endmodule

// File: rtl/agen_update.sv
module agen_update #(
  parameter int AW  = 32,
  parameter int CSW = 5
) (
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  offset,
  input  logic           subtract,
  input  logic           circular,
  input  logic [CSW-1:0] blk,
  output logic [AW-1:0]  result
);
  localparam int SHW = CSW + 1;
  logic [AW-1:0]  sum;
  logic [AW-1:0]  keep_low;
  logic [SHW-1:0] span;

  always_comb begin
    sum      = subtract ? (base - offset) : (base + offset);
    span     = SHW'(blk) + SHW'(1);
    keep_low = ~({AW{1'b1}} << span);
    if (circular)
      result = (base & ~keep_low) | (sum & keep_low);
    else
      result = sum;
  end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int AW        = 32,
  parameter int RIDXW     = 4,
  parameter int SHORTW    = 5,
  parameter int IMMW      = 15,
  parameter int CSW       = 5,
  parameter int CIRC_LO   = 4,
  parameter int CIRC_HI   = 7,
  parameter int LONG_BANK = 1,
  parameter int LONG_LO   = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             base_bank,
  input  logic [RIDXW-1:0] base_idx,
  input  logic [AW-1:0]    base_val,
  input  logic [AW-1:0]    index_val,
  input  logic [IMMW-1:0]  imm,
  input  logic [1:0]       off_kind,
  input  logic [1:0]       acc_size,
  input  logic [2:0]       mode,
  input  logic             circ_en,
  input  logic [CSW-1:0]   circ_size,
  output logic             out_valid,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    wb_data,
  output logic             wb_en,
  output logic             bad_form
);
  import agen_pkg::*;
  localparam int LONG_HI = LONG_LO + 1;

  logic [AW-1:0] scaled, updated;
  logic          is_sub, is_post, is_wb, circ_ok, long_ok, legal;

  agen_offset #(.AW(AW), .SHORTW(SHORTW), .IMMW(IMMW)) u_off (
    .kind(off_kind), .imm(imm), .index_val(index_val),
    .size(acc_size), .scaled(scaled)
  );

  always_comb begin
    is_sub  = (mode == MD_PRE_DEC) || (mode == MD_POST_DEC) || (mode == MD_SUB_ONLY);
    is_post = (mode == MD_POST_INC) || (mode == MD_POST_DEC);
    is_wb   = (mode >= MD_PRE_INC) && (mode <= MD_POST_DEC);
    circ_ok = circ_en && (int'(base_idx) >= CIRC_LO) && (int'(base_idx) <= CIRC_HI);
    long_ok = (int'(base_bank) == LONG_BANK) && (int'(base_idx) >= LONG_LO) &&
              (int'(base_idx) <= LONG_HI) && (mode == MD_ADD_ONLY);
    legal   = (mode <= MD_SUB_ONLY) && (off_kind != 2'd3) &&
              ((off_kind != OK_LONG) || long_ok);
  end

  agen_update #(.AW(AW), .CSW(CSW)) u_upd (
    .base(base_val), .offset(scaled), .subtract(is_sub),
    .circular(circ_ok), .blk(circ_size), .result(updated)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      mem_addr  <= '0;
      wb_data   <= '0;
      wb_en     <= 1'b0;
      bad_form  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        mem_addr <= is_post ? base_val : updated;
        wb_data  <= updated;
        wb_en    <= legal && is_wb;
        bad_form <= !legal;
      end else begin
        wb_en    <= 1'b0;
        bad_form <= 1'b0;
      end
    end
  end

  logic [AW-1:0] hold_mask;
  assign hold_mask = {AW{1'b1}} << ((CSW+1)'(circ_size) + (CSW+1)'(1));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid && !wb_en);
  assert_pre_match_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid && (mode == MD_PRE_INC || mode == MD_PRE_DEC) && off_kind != 2'd3 && off_kind != 2'd2
    |=> wb_en && mem_addr == wb_data);
  assert_post_base_R6: assert property (@(posedge clk) disable iff (rst)
    req_valid && (mode == MD_POST_INC || mode == MD_POST_DEC)
    |=> mem_addr == $past(base_val));
  assert_nomod_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid && (mode == MD_ADD_ONLY || mode == MD_SUB_ONLY) |=> !wb_en);
  assert_bad_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && mode > MD_SUB_ONLY |=> bad_form && !wb_en);
  assert_circ_hold_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid && circ_en && int'(base_idx) >= CIRC_LO && int'(base_idx) <= CIRC_HI
    |=> ((wb_data ^ $past(base_val)) & $past(hold_mask)) == '0);
endmodule

// File: tb/ldst_agen_tb.sv
module ldst_agen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, base_bank, circ_en;
  logic [3:0]  base_idx;
  logic [31:0] base_val, index_val;
  logic [14:0] imm;
  logic [1:0]  off_kind, acc_size;
  logic [2:0]  mode;
  logic [4:0]  circ_size;
  logic        out_valid, wb_en, bad_form;
  logic [31:0] mem_addr, wb_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ldst_agen u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .base_bank(base_bank),
    .base_idx(base_idx), .base_val(base_val), .index_val(index_val),
    .imm(imm), .off_kind(off_kind), .acc_size(acc_size), .mode(mode),
    .circ_en(circ_en), .circ_size(circ_size), .out_valid(out_valid),
    .mem_addr(mem_addr), .wb_data(wb_data), .wb_en(wb_en), .bad_form(bad_form)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input string tag);
    logic [31:0] off, sum, mod, mask, e_addr;
    logic        leg, wbm, circ, sub, post;
    int          sh;
    off  = (off_kind == 0) ? {27'd0, imm[4:0]} : (off_kind == 1) ? index_val : {17'd0, imm};
    sh   = (acc_size == 3) ? 2 : int'(acc_size);
    off  = off << sh;
    sub  = (mode == 2) || (mode == 4) || (mode == 5);
    post = (mode == 3) || (mode == 4);
    sum  = sub ? base_val - off : base_val + off;
    circ = circ_en && base_idx >= 4 && base_idx <= 7;
    mask = (circ_size == 31) ? 32'hFFFF_FFFF : ((32'd1 << (circ_size + 1)) - 1);
    mod  = circ ? ((base_val & ~mask) | (sum & mask)) : sum;
    e_addr = post ? base_val : mod;
    leg  = (mode <= 5) && (off_kind != 3) &&
           (off_kind != 2 || (base_bank && base_idx >= 14 && mode == 0));
    wbm  = leg && mode >= 1 && mode <= 4;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 out_valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " R8 bad_form"}, {31'd0, bad_form}, {31'd0, !leg});
    chk({tag, " R5/R6/R7 wb_en"}, {31'd0, wb_en}, {31'd0, wbm});
    if (leg) begin
      chk({tag, " R3/R4/R5/R6/R7/R9/R10/R11 mem_addr"}, mem_addr, e_addr);
      if (wbm) chk({tag, " R5/R6/R10 wb_data"}, wb_data, mod);
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 0; base_bank = 0; base_idx = 0; base_val = 0;
    index_val = 0; imm = 0; off_kind = 0; acc_size = 0; mode = 0;
    circ_en = 0; circ_size = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset wb_en", {31'd0, wb_en}, 32'd0);
    chk("R1 reset bad", {31'd0, bad_form}, 32'd0);
    chk("R1 reset addr", mem_addr, 32'd0);
    chk("R1 reset wb", wb_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset valid", {31'd0, out_valid}, 32'd0);

    // R3 word offset 9 gives base + 36
    base_idx = 4'd3; base_val = 32'h0000_1000; imm = 15'd9; off_kind = 0;
    acc_size = 2; mode = 1;
    run_one("R3 word x9");
    chk("R3 word x9 exact", mem_addr, 32'h0000_1024);
    // R11 linear wrap
    base_val = 32'hFFFF_FFFC; imm = 15'd1; mode = 3;
    run_one("R11 wrap");
    chk("R11 wrap exact", wb_data, 32'h0000_0000);
    // R10 smallest block: only bit 0 changes
    base_idx = 4'd5; circ_en = 1; circ_size = 0; base_val = 32'h0000_0101;
    acc_size = 0; mode = 1;
    run_one("R10 small blk");
    chk("R10 small blk exact", wb_data, 32'h0000_0100);
    // R9 ineligible register ignores circ_en
    base_idx = 4'd8;
    run_one("R9 linear reg");
    chk("R9 linear exact", wb_data, 32'h0000_0102);
    // idle cycle
    @(negedge clk);
    chk("R2 idle", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < 6144; i++) begin
      base_idx  = 4'(i % 16);
      base_bank = 1'((i / 16) % 2);
      mode      = 3'((i / 32) % 8);
      acc_size  = 2'((i / 256) % 4);
      off_kind  = 2'((i / 1024) % 3);
      circ_en   = 1'((i / 3072) % 2);
      base_val  = 32'h9E37_79B9 * (i + 1);
      index_val = 32'h7F4A_7C15 * (i + 3);
      imm       = 15'((i * 2654435) ^ (i >> 3));
      circ_size = 5'((i * 7) % 32);
      @(negedge clk);
      run_one("sweep");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule